// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a set of on-chip sources and presents one request line to the CPU. Each source has a 3-bit priority level and a recognition mode. An edge-mode source latches a pending flag on a rising edge. A level-mode source follows its input. A sequencer repeatedly runs a pipelined priority tree over the pending sources whose level is below the current mask. When it finds a winner, it latches that source's vector and level and raises the CPU request.

Software uses a small register window. Reading the vector register tells the handler which source was accepted. That read also acts on the hardware: it moves the mask to the accepted level, clears an edge-mode source, drops the CPU request and restarts resolution. Writing the mask register drops the request and restarts resolution, even when the value written is the current one. The vector value for source `k` is computed as `VEC_BASE + k*VEC_STEP`, truncated to 16 bits.

Top module: `irqc_top`

## Requirements
- R1: After reset the mask is 7, the CPU request is low, and every source control register reads level 7 (disabled), edge mode set and pending clear, which is value 0x000F.
- R2: An edge-mode source sets its pending flag on a rising edge of its input after a two-flop synchronizer. The flag stays set after the input falls.
- R3: A level-mode source's pending flag equals its synchronized input.
- R4: A pending source can win only if its level is numerically below the mask. Level 7 never wins.
- R5: Among eligible sources, the lowest level wins. On equal levels, the lowest source index wins.
- R6: After a restart, the request stays low through resolution. If a winner exists, the request rises on the STAGES+2-th clock edge after the restarting access, where STAGES = ceil(log2(N_SRC)).
- R7: The register map is as follows. Address 0 reads the vector. Address 1 is the mask, in bits [2:0]. Address 2+k is source k's control register: [2:0] level, [3] edge mode (1 = edge), [4] write-1-to-clear pending (reads 0), [5] pending (read-only). Any other address reads 0. The vector equals VEC_BASE + k*VEC_STEP.
- R8: A vector read while the request is high loads the accepted level into the mask. The request drops on that clock edge, and resolution restarts.
- R9: That read clears the accepted source's pending flag when the source is in edge mode, and leaves a level-mode source pending.
- R10: Any mask write drops the request on that edge and restarts resolution.
- R11: Writing 1 to control bit 4 clears that source's pending flag.
- R12: While the request is high and no vector read or mask write occurs, the request stays high and the latched vector and level do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Raw interrupt inputs, one per source |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with N_SRC = 5, VEC_BASE = 0x0200 and VEC_STEP = 8. Five sources do not fill a power of two, so the padded leaves of the three-stage tree are exercised. With this small size the bench can sweep every ordered pair of sources over all 64 level combinations, and it can cross all mask values with all levels. The bench also checks the exact five-edge resolution latency and the different clearing behaviour of edge-mode and level-mode sources.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W     = 3;
  localparam int DATA_W    = 16;
  localparam logic [LVL_W-1:0] LVL_OFF = 3'd7;
  localparam int CTL_EDGE  = 3;
  localparam int CTL_CLR   = 4;
  localparam int CTL_PEND  = 5;
  localparam int ADDR_VEC  = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_SRC0 = 2;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
  import irqc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       src_in,
  input  logic [N_SRC-1:0]       cfg_we,
  input  logic [4:0]             cfg_wdata,
  input  logic                   acc_clr,
  input  logic [IW-1:0]          acc_idx,
  output logic [N_SRC-1:0]       pend,
  output logic [N_SRC*LVL_W-1:0] lvl_flat,
  output logic [N_SRC-1:0]       edge_mode
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [1:0]       sync_q;
    logic             prev_q;
    logic             pend_q;
    logic             mode_q;
    logic [LVL_W-1:0] lvl_q;
    logic             rise;
    logic             clr;

    assign rise = sync_q[1] && !prev_q;
    assign clr  = (cfg_we[i] && cfg_wdata[CTL_CLR]) ||
                  (acc_clr && acc_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
        pend_q <= 1'b0;
        mode_q <= 1'b1;
        lvl_q  <= LVL_OFF;
      end else begin
        sync_q <= {sync_q[0], src_in[i]};
        prev_q <= sync_q[1];
        if (cfg_we[i]) begin
          lvl_q  <= cfg_wdata[LVL_W-1:0];
          mode_q <= cfg_wdata[CTL_EDGE];
        end
        if (rise)     pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
      end
    end

    assign pend[i]                   = mode_q ? pend_q : sync_q[1];
    assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q;
    assign edge_mode[i]              = mode_q;
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int STAGES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [N_SRC-1:0]       elig,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  output logic                   win_v,
  output logic [LVL_W-1:0]       win_lvl,
  output logic [STAGES-1:0]      win_idx
);
  localparam int P     = 1 << STAGES;
  localparam int NODES = 2 * P - 1;

  logic [P-1:0]       elig_p;
  logic [P*LVL_W-1:0] lvl_p;

  if (P > N_SRC) begin : g_pad
    assign elig_p = {{(P-N_SRC){1'b0}}, elig};
    assign lvl_p  = {{(P-N_SRC){LVL_OFF}}, lvl_flat};
  end else begin : g_nopad
    assign elig_p = elig;
    assign lvl_p  = lvl_flat;
  end

  logic              nv [NODES];
  logic [LVL_W-1:0]  nl [NODES];
  logic [STAGES-1:0] nx [NODES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NODES; k++) begin
        nv[k] <= 1'b0;
        nl[k] <= LVL_OFF;
        nx[k] <= '0;
      end
    end else begin
      if (load) begin
        for (int j = 0; j < P; j++) begin
          nv[P-1+j] <= elig_p[j];
          nl[P-1+j] <= lvl_p[j*LVL_W +: LVL_W];
          nx[P-1+j] <= STAGES'(j);
        end
      end
      for (int k = 0; k < P - 1; k++) begin
        if (nv[2*k+1] && (!nv[2*k+2] || nl[2*k+1] <= nl[2*k+2])) begin
          nv[k] <= 1'b1;
          nl[k] <= nl[2*k+1];
          nx[k] <= nx[2*k+1];
        end else begin
          nv[k] <= nv[2*k+2];
          nl[k] <= nl[2*k+2];
          nx[k] <= nx[2*k+2];
        end
      end
    end
  end

  assign win_v   = nv[0];
  assign win_lvl = nl[0];
  assign win_idx = nx[0];
endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
  import irqc_pkg::*;
#(
  parameter int STAGES   = 3,
  parameter int VEC_BASE = 256,
  parameter int VEC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               win_v,
  input  logic [LVL_W-1:0]   win_lvl,
  input  logic [STAGES-1:0]  win_idx,
  output logic               load,
  output logic               busy,
  output logic               irq,
  output logic [DATA_W-1:0]  acc_vec,
  output logic [LVL_W-1:0]   acc_lvl,
  output logic [STAGES-1:0]  acc_idx
);
  localparam int LAT = STAGES + 1;
  localparam int CW  = $clog2(LAT + 1) + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b1;
      cnt     <= '0;
      irq     <= 1'b0;
      acc_vec <= '0;
      acc_lvl <= LVL_OFF;
      acc_idx <= '0;
    end else if (restart) begin
      busy <= 1'b1;
      cnt  <= '0;
      irq  <= 1'b0;
    end else if (busy) begin
      if (cnt == CW'(LAT)) begin
        cnt <= '0;
        if (win_v) begin
          busy    <= 1'b0;
          irq     <= 1'b1;
          acc_lvl <= win_lvl;
          acc_idx <= win_idx;
          acc_vec <= DATA_W'(VEC_BASE + VEC_STEP * int'(win_idx));
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign load = busy && (cnt == '0);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_BASE = 256,
  parameter int VEC_STEP = 4,
  localparam int STAGES  = $clog2(N_SRC),
  localparam int ADDR_W  = $clog2(N_SRC + ADDR_SRC0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              cpu_irq
);
  logic                   vec_rd, mask_wr, restart;
  logic [LVL_W-1:0]       mask_q;
  logic [N_SRC-1:0]       cfg_we, pend, edge_mode, elig;
  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic                   load, seq_busy, win_v;
  logic [LVL_W-1:0]       win_lvl, acc_lvl;
  logic [STAGES-1:0]      win_idx, acc_idx;
  logic [DATA_W-1:0]      acc_vec;
  logic                   unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:5];

  assign vec_rd  = bus_sel && !bus_wr && bus_addr == ADDR_W'(ADDR_VEC);
  assign mask_wr = bus_sel &&  bus_wr && bus_addr == ADDR_W'(ADDR_MASK);
  assign restart = vec_rd || mask_wr;

  for (genvar i = 0; i < N_SRC; i++) begin : g_dec
    assign cfg_we[i] = bus_sel && bus_wr && bus_addr == ADDR_W'(ADDR_SRC0 + i);
    assign elig[i]   = pend[i] && (lvl_flat[i*LVL_W +: LVL_W] < mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 mask_q <= LVL_OFF;
    else if (mask_wr)           mask_q <= bus_wdata[LVL_W-1:0];
    else if (vec_rd && cpu_irq) mask_q <= acc_lvl;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADDR_VEC)) begin
      bus_rdata = acc_vec;
    end else if (bus_addr == ADDR_W'(ADDR_MASK)) begin
      bus_rdata = {{(DATA_W-LVL_W){1'b0}}, mask_q};
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (bus_addr == ADDR_W'(ADDR_SRC0 + i))
          bus_rdata = {10'b0, pend[i], 1'b0, edge_mode[i], lvl_flat[i*LVL_W +: LVL_W]};
      end
    end
  end

  irqc_src_bank #(.N_SRC(N_SRC), .IW(STAGES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .cfg_we    (cfg_we),
    .cfg_wdata (bus_wdata[4:0]),
    .acc_clr   (vec_rd && cpu_irq),
    .acc_idx   (acc_idx),
    .pend      (pend),
    .lvl_flat  (lvl_flat),
    .edge_mode (edge_mode)
  );

  irqc_arbiter #(.N_SRC(N_SRC), .STAGES(STAGES)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .elig     (elig),
    .lvl_flat (lvl_flat),
    .win_v    (win_v),
    .win_lvl  (win_lvl),
    .win_idx  (win_idx)
  );

  irqc_seq #(.STAGES(STAGES), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .win_v   (win_v),
    .win_lvl (win_lvl),
    .win_idx (win_idx),
    .load    (load),
    .busy    (seq_busy),
    .irq     (cpu_irq),
    .acc_vec (acc_vec),
    .acc_lvl (acc_lvl),
    .acc_idx (acc_idx)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_irq,
  input logic        busy,
  input logic        vec_rd,
  input logic        mask_wr,
  input logic [2:0]  mask_q,
  input logic [2:0]  acc_lvl,
  input logic [15:0] acc_vec
);
  // R6: request stays low while the tree is resolving
  p_quiet_resolve_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cpu_irq);

  // R4: an asserted request always carries a level below the mask
  p_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (acc_lvl < mask_q));

  // R8: accepting read moves the mask and drops the request
  p_vec_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && cpu_irq) |=> (!cpu_irq && mask_q == $past(acc_lvl)));

  // R10: any mask write drops the request
  p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> !cpu_irq);

  // R12: held request keeps its vector and level
  p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && !vec_rd && !mask_wr) |=> (cpu_irq && $stable(acc_vec) && $stable(acc_lvl)));
endmodule

bind irqc_top irqc_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cpu_irq (cpu_irq),
  .busy    (seq_busy),
  .vec_rd  (vec_rd),
  .mask_wr (mask_wr),
  .mask_q  (mask_q),
  .acc_lvl (acc_lvl),
  .acc_vec (acc_vec)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  localparam int N  = 5;
  localparam int VB = 16'h0200;
  localparam int VS = 8;
  localparam int AW = 3;
  localparam int LAT = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_in = '0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic          cpu_irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqc_top #(.N_SRC(N), .VEC_BASE(VB), .VEC_STEP(VS)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_irq(input int n, output bit got);
    got = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (cpu_irq) begin got = 1; break; end
    end
  endtask

  task automatic pulse(input int a, input int b);
    @(negedge clk);
    src_in[a] = 1; src_in[b] = 1;
    @(negedge clk);
    src_in[a] = 0; src_in[b] = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) wr(2 + i, 16'h001F);
    wr(1, 7);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int d;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check(cpu_irq == 0, "R1 irq", cpu_irq, 0);
    rd(1, d); check(d == 7, "R1 mask", d, 7);
    for (int i = 0; i < N; i++) begin
      rd(2 + i, d); check(d == 16'h000F, "R1 ctrl", d, 16'h000F);
    end
    wait_irq(20, got); check(got == 0, "R1 no irq", got, 0);

    // R7: register map
    wr(1, 5); rd(1, d); check(d == 5, "R7 mask rw", d, 5);
    rd(7, d); check(d == 0, "R7 unmapped", d, 0);
    wr(3, 16'h0004); rd(3, d); check(d == 16'h0004, "R7 ctrl rw", d, 4);

    // R2: sticky edge pending
    clear_all(); wr(1, 0); wr(5, 16'h0009); pulse(3, 3);
    repeat (5) @(negedge clk);
    rd(5, d); check(d == 16'h0029, "R2 sticky", d, 16'h0029);

    // R5/R7/R8/R9: pairwise sweep
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        for (int li = 0; li < 8; li++)
          for (int lj = 0; lj < 8; lj++) begin
            int w, wl, o, ol;
            w  = (li <= lj) ? i : j;
            wl = (li <= lj) ? li : lj;
            o  = (w == i) ? j : i;
            ol = (w == i) ? lj : li;
            clear_all();
            wr(2 + i, 8 + li); wr(2 + j, 8 + lj);
            pulse(i, j);
            wait_irq(20, got);
            check(got == (wl != 7), "R5 winner exists", got, wl != 7);
            if (got) begin
              rd(0, d); check(d == VB + w * VS, "R5 R7 vector", d, VB + w * VS);
              check(cpu_irq == 0, "R8 drop", cpu_irq, 0);
              rd(1, d); check(d == wl, "R8 mask load", d, wl);
              wr(1, 7);
              wait_irq(20, got);
              check(got == (ol != 7), "R9 other fires", got, ol != 7);
              if (got) begin
                rd(0, d); check(d == VB + o * VS, "R5 second vector", d, VB + o * VS);
                wr(1, 7);
                wait_irq(20, got);
                check(got == 0, "R9 edge cleared", got, 0);
              end
            end
          end

    // R4: mask versus level sweep
    for (int kk = 0; kk < 2; kk++)
      for (int l = 0; l < 8; l++)
        for (int m = 0; m < 8; m++) begin
          int k;
          k = kk * 4;
          clear_all();
          wr(2 + k, 8 + l); wr(1, m);
          pulse(k, k);
          wait_irq(20, got);
          check(got == (l < m), "R4 eligibility", got, l < m);
        end

    // R6 exact latency, R12 hold, R10 mask write
    clear_all(); wr(4, 16'h000B); pulse(2, 2);
    wait_irq(20, got); check(got == 1, "R6 setup irq", got, 1);
    wr(1, 7);
    for (int c = 0; c < LAT - 1; c++) begin
      @(negedge clk); check(cpu_irq == 0, "R6 low in resolve", cpu_irq, 0);
    end
    @(negedge clk); check(cpu_irq == 1, "R6 rise edge", cpu_irq, 1);
    repeat (10) @(negedge clk);
    check(cpu_irq == 1, "R12 held", cpu_irq, 1);
    rd(0, d); check(d == VB + 2 * VS, "R12 vector", d, VB + 2 * VS);
    clear_all(); wr(4, 16'h000B); pulse(2, 2);
    wait_irq(20, got);
    wr(1, 3);
    check(cpu_irq == 0, "R10 drop", cpu_irq, 0);
    wait_irq(20, got); check(got == 0, "R10 equal mask blocks", got, 0);
    wr(1, 4);
    wait_irq(20, got); check(got == 1, "R10 restart fires", got, 1);

    // R11: software clear
    wr(4, 16'h001B);
    rd(4, d); check(d == 16'h000B, "R11 pending cleared", d, 16'h000B);
    wr(1, 7);
    wait_irq(20, got); check(got == 0, "R11 no irq", got, 0);

    // R3/R9: level-mode source
    clear_all(); wr(3, 16'h0002);
    @(negedge clk); src_in[1] = 1;
    repeat (4) @(negedge clk);
    rd(3, d); check(d == 16'h0022, "R3 follows high", d, 16'h0022);
    wr(1, 7);
    wait_irq(20, got); check(got == 1, "R3 irq", got, 1);
    rd(0, d); check(d == VB + VS, "R3 vector", d, VB + VS);
    rd(1, d); check(d == 2, "R8 level mask", d, 2);
    wr(1, 7);
    wait_irq(20, got); check(got == 1, "R9 level not cleared", got, 1);
    @(negedge clk); src_in[1] = 0;
    repeat (4) @(negedge clk);
    rd(3, d); check(d == 16'h0002, "R3 follows low", d, 16'h0002);
    wr(1, 7);
    wait_irq(20, got); check(got == 0, "R3 no irq", got, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    done = 1;
    $finish;
  end
endmodule